// File: doc/BRIEF.md
# Boot Sector Lock and Identification Responder

This block sits beside the command decoder of a sector-programmed flash array. It keeps three persistent protection flags: a lock for the lowest boot region, a lock for the highest boot region, and a software write-protect flag. When the command decoder finishes the boot-lock command it sends a one-cycle arm pulse. The block then treats the next bus write as the parameter of that command. A write of all-zero data to address zero locks the lower region. A write of all-ones data to the highest address locks the upper region. Any other write only cancels the armed state, and the array logic then handles that write as usual.

The block also answers reads while identification mode is on. In that mode the manufacturer code, the device code and the two lock states appear at fixed addresses, and every other address reads as zero. The block raises a valid flag so that its data takes the place of the normal array read. For every write it also reports two things: whether the write was consumed as a lock parameter, and whether the write falls inside a locked boot region. The flags themselves are not stored across power loss here. Their starting values come from a reset parameter.

Two small state machines do the work. The arm machine has the states ARM_IDLE and ARM_WAIT:
- ARM_IDLE goes to ARM_WAIT on an arm pulse.
- ARM_WAIT goes back to ARM_IDLE on any write, unless an arm pulse arrives in the same cycle.

The identification machine has the states IDM_OFF and IDM_ON:
- IDM_OFF goes to IDM_ON on an entry request.
- IDM_ON goes back to IDM_OFF on an exit request. An exit request wins over an entry request in the same cycle.

Top module: `boot_guard_id`

## Requirements
- R1: After reset, identification mode is off, the arm machine is in ARM_IDLE, and the three flags equal the RESET_FLAGS parameter.
- R2: After an arm pulse, a write of data 0x00 to address 0 drives wr_taken high in that cycle, and lock_lo is set from the next cycle on.
- R3: After an arm pulse, a write of data 0xFF to the highest address (all ones) drives wr_taken high in that cycle, and lock_hi is set from the next cycle on.
- R4: After an arm pulse, any other address/data pair leaves wr_taken low and sets no lock. It also disarms the block, so a later matching write without a new arm pulse sets nothing.
- R5: Once set, a lock flag stays set until reset. No write-protect, identification or arm activity clears it.
- R6: id_valid is high only in a cycle where identification mode is on and bus_rd is high. Entry takes effect in the cycle after the request, and so does exit.
- R7: In identification mode, address 0 reads 0x1F and address 1 reads the DEVICE_CODE parameter.
- R8: In identification mode, address 2 reads 0xFF when lock_lo is set and 0xFE when it is clear. The address 13 below the highest address reports lock_hi in the same way.
- R9: In identification mode, every other address reads 0x00.
- R10: status_byte carries lock_lo in bit 2, lock_hi in bit 1 and wprot in bit 0. Its other bits are zero.
- R11: wp_set alone sets wprot in the next cycle, and wp_clr alone clears it. When both arrive together, wprot is unchanged.
- R12: wr_blocked is high for a write that is not taken as a lock parameter in two cases: the address is below BOOT_BYTES while lock_lo is set, or the address is in the top BOOT_BYTES while lock_hi is set.
- R13: With no arm pulse pending, no write is taken and no write changes a lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_lock | input | 1 | Pulse: the boot-lock command has been decoded |
| id_enter | input | 1 | Request to enter identification mode |
| id_exit | input | 1 | Request to leave identification mode |
| wp_set | input | 1 | Request to set the write-protect flag |
| wp_clr | input | 1 | Request to clear the write-protect flag |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_wdata | input | DATA_W | Bus write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| lock_lo | output | 1 | Lower boot region lock |
| lock_hi | output | 1 | Upper boot region lock |
| wprot | output | 1 | Software write-protect flag |
| status_byte | output | 8 | Packed flags: bit 2 lower lock, bit 1 upper lock, bit 0 protect |
| wr_taken | output | 1 | The current write is consumed as a lock parameter |
| wr_blocked | output | 1 | The current write targets a locked boot region |
| id_rdata | output | DATA_W | Identification read data, zero when not valid |
| id_valid | output | 1 | Identification data replaces the array read |

## Verification
The bench builds the block with a 15-bit address space (32 KiB), 4 KiB boot regions, device code 0xDC and RESET_FLAGS of 3'b001. This places the highest address at 0x7FFF and the upper-lock identification address at 0x7FF2. With these values the upper region and its edge at 0x7000 can be reached with short address values, and they sit far from the lower region. The write-protect flag starting at 1 shows that the reset value reaches the flags and is not hard-wired to zero. The sequence first locks the lower region and then the upper one, so the checks cover lock reporting, blocking at each region edge, and the flags holding their values against later commands.

// File: rtl/lockid_pkg.sv
`timescale 1ns/1ps
package lockid_pkg;

    typedef enum logic {ARM_IDLE, ARM_WAIT} arm_state_e;
    typedef enum logic {IDM_OFF, IDM_ON}    idm_state_e;

    // Field order matches the packed status byte: [2] lower, [1] upper, [0] protect
    typedef struct packed {
        logic lock_lo;
        logic lock_hi;
        logic wprot;
    } guard_flags_t;

    localparam logic [7:0] MFR_CODE        = 8'h1F;
    localparam int         ID_HI_BACKSTEP  = 13;

endpackage

// File: rtl/lock_arm_fsm.sv
`timescale 1ns/1ps
module lock_arm_fsm
    import lockid_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              set_lo_o,
    output logic              set_hi_o,
    output logic              take_o
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    arm_state_e state_q, state_d;
    logic       lo_pair, hi_pair;

    assign lo_pair = (addr_i == '0)      && (data_i == '0);
    assign hi_pair = (addr_i == TOP_ADDR) && (data_i == '1);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_IDLE: if (arm_i) state_d = ARM_WAIT;
            ARM_WAIT: if (wr_i && !arm_i) state_d = ARM_IDLE;
        endcase
    end

    always_comb begin
        set_lo_o = 1'b0;
        set_hi_o = 1'b0;
        unique case (state_q)
            ARM_IDLE: ;
            ARM_WAIT: begin
                set_lo_o = wr_i && lo_pair;
                set_hi_o = wr_i && hi_pair;
            end
        endcase
        take_o = set_lo_o || set_hi_o;
    end

    // R4: a write while armed ends the armed state
    p_disarm_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARM_WAIT && wr_i && !arm_i) |=> (state_q == ARM_IDLE));

    // R13: nothing is consumed unless armed
    p_take_needs_arm_r13: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (state_q == ARM_WAIT));

endmodule

// File: rtl/guard_flag_reg.sv
`timescale 1ns/1ps
module guard_flag_reg
    import lockid_pkg::*;
#(
    parameter logic [2:0] RESET_FLAGS = 3'b000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_lo_i,
    input  logic         set_hi_i,
    input  logic         wp_set_i,
    input  logic         wp_clr_i,
    output guard_flags_t flags_o
);

    guard_flags_t flags_q, flags_d;

    always_comb begin
        flags_d = flags_q;
        if (set_lo_i) flags_d.lock_lo = 1'b1;
        if (set_hi_i) flags_d.lock_hi = 1'b1;
        if (wp_set_i && !wp_clr_i) flags_d.wprot = 1'b1;
        if (wp_clr_i && !wp_set_i) flags_d.wprot = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= guard_flags_t'(RESET_FLAGS);
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    p_lo_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q.lock_lo |=> flags_q.lock_lo);

    p_hi_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q.lock_hi |=> flags_q.lock_hi);

    p_wp_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_set_i && !wp_clr_i) |=> flags_q.wprot);

    p_wp_tie_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_set_i && wp_clr_i) |=> $stable(flags_q.wprot));

endmodule

// File: rtl/id_responder.sv
`timescale 1ns/1ps
module id_responder
    import lockid_pkg::*;
#(
    parameter int              ADDR_W      = 19,
    parameter int              DATA_W      = 8,
    parameter logic [DATA_W-1:0] DEVICE_CODE = 8'hA4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_i,
    input  logic              exit_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              lock_lo_i,
    input  logic              lock_hi_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              valid_o
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
    localparam logic [ADDR_W-1:0] HI_ID_ADDR = TOP_ADDR - ADDR_W'(ID_HI_BACKSTEP);
    localparam logic [DATA_W-1:0] LOCK_YES = '1;
    localparam logic [DATA_W-1:0] LOCK_NO  = ~DATA_W'(1);

    idm_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IDM_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDM_OFF: if (enter_i && !exit_i) state_d = IDM_ON;
            IDM_ON:  if (exit_i)             state_d = IDM_OFF;
        endcase
    end

    always_comb begin
        valid_o = 1'b0;
        rdata_o = '0;
        unique case (state_q)
            IDM_OFF: ;
            IDM_ON: begin
                valid_o = rd_i;
                if (rd_i) begin
                    if (addr_i == ADDR_W'(0))
                        rdata_o = DATA_W'(MFR_CODE);
                    else if (addr_i == ADDR_W'(1))
                        rdata_o = DEVICE_CODE;
                    else if (addr_i == ADDR_W'(2))
                        rdata_o = lock_lo_i ? LOCK_YES : LOCK_NO;
                    else if (addr_i == HI_ID_ADDR)
                        rdata_o = lock_hi_i ? LOCK_YES : LOCK_NO;
                end
            end
        endcase
    end

    p_id_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exit_i |=> (state_q == IDM_OFF));

    p_valid_needs_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> rd_i);

endmodule

// File: rtl/boot_guard_id.sv
`timescale 1ns/1ps
module boot_guard_id
    import lockid_pkg::*;
#(
    parameter int                ADDR_W      = 19,
    parameter int                DATA_W      = 8,
    parameter int                BOOT_BYTES  = 16384,
    parameter logic [DATA_W-1:0] DEVICE_CODE = 8'hA4,
    parameter logic [2:0]        RESET_FLAGS = 3'b000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_lock,
    input  logic              id_enter,
    input  logic              id_exit,
    input  logic              wp_set,
    input  logic              wp_clr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic              lock_lo,
    output logic              lock_hi,
    output logic              wprot,
    output logic [7:0]        status_byte,
    output logic              wr_taken,
    output logic              wr_blocked,
    output logic [DATA_W-1:0] id_rdata,
    output logic              id_valid
);

    localparam longint SPACE   = longint'(1) << ADDR_W;
    localparam logic [ADDR_W-1:0] LO_LIMIT = ADDR_W'(BOOT_BYTES);
    localparam logic [ADDR_W-1:0] HI_BASE  = ADDR_W'(SPACE - longint'(BOOT_BYTES));

    guard_flags_t flags;
    logic         set_lo, set_hi;
    logic         in_lo_region, in_hi_region;

    lock_arm_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (arm_lock),
        .wr_i     (bus_wr),
        .addr_i   (bus_addr),
        .data_i   (bus_wdata),
        .set_lo_o (set_lo),
        .set_hi_o (set_hi),
        .take_o   (wr_taken)
    );

    guard_flag_reg #(.RESET_FLAGS(RESET_FLAGS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_lo_i (set_lo),
        .set_hi_i (set_hi),
        .wp_set_i (wp_set),
        .wp_clr_i (wp_clr),
        .flags_o  (flags)
    );

    id_responder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEVICE_CODE(DEVICE_CODE)) u_id (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter_i   (id_enter),
        .exit_i    (id_exit),
        .rd_i      (bus_rd),
        .addr_i    (bus_addr),
        .lock_lo_i (flags.lock_lo),
        .lock_hi_i (flags.lock_hi),
        .rdata_o   (id_rdata),
        .valid_o   (id_valid)
    );

    assign lock_lo     = flags.lock_lo;
    assign lock_hi     = flags.lock_hi;
    assign wprot       = flags.wprot;
    assign status_byte = {5'b00000, flags};

    assign in_lo_region = bus_addr < LO_LIMIT;
    assign in_hi_region = bus_addr >= HI_BASE;
    assign wr_blocked   = bus_wr && !wr_taken &&
                          ((flags.lock_lo && in_lo_region) || (flags.lock_hi && in_hi_region));

    // R2/R3: a consumed parameter write always leaves a lock set
    p_taken_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_taken |=> (lock_lo || lock_hi));

    // R12: a write is never both consumed and blocked
    p_blocked_not_taken_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_blocked |-> !wr_taken);

endmodule

// File: tb/test_boot_guard_id.sv
`timescale 1ns/1ps
module test_boot_guard_id;

    localparam int AW = 15;
    localparam int DW = 8;

    typedef struct {
        string      req;
        int         kind;
        logic [7:0] exp;
    } item_t;

    localparam int K_STATUS  = 0;
    localparam int K_IDDATA  = 1;
    localparam int K_VALID   = 2;
    localparam int K_TAKEN   = 3;
    localparam int K_BLOCKED = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm_lock = 0, id_enter = 0, id_exit = 0, wp_set = 0, wp_clr = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_wr = 0, bus_rd = 0;
    logic          lock_lo, lock_hi, wprot, wr_taken, wr_blocked, id_valid;
    logic [7:0]    status_byte;
    logic [DW-1:0] id_rdata;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    item_t sb_q[$];
    item_t it;
    logic [7:0] act;

    always #2.5 clk = ~clk;

    boot_guard_id #(
        .ADDR_W(AW), .DATA_W(DW), .BOOT_BYTES(4096),
        .DEVICE_CODE(8'hDC), .RESET_FLAGS(3'b001)
    ) i_boot_guard_id (
        .clk(clk), .rst_n(rst_n), .arm_lock(arm_lock), .id_enter(id_enter),
        .id_exit(id_exit), .wp_set(wp_set), .wp_clr(wp_clr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .lock_lo(lock_lo),
        .lock_hi(lock_hi), .wprot(wprot), .status_byte(status_byte), .wr_taken(wr_taken),
        .wr_blocked(wr_blocked), .id_rdata(id_rdata), .id_valid(id_valid)
    );

    // monitor: pops and compares every pending expectation away from the edge
    always @(negedge clk) begin
        while (sb_q.size() != 0) begin
            it = sb_q.pop_front();
            case (it.kind)
                K_STATUS:  act = status_byte;
                K_IDDATA:  act = id_valid ? id_rdata : 8'hEE;
                K_VALID:   act = {7'b0, id_valid};
                K_TAKEN:   act = {7'b0, wr_taken};
                default:   act = {7'b0, wr_blocked};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic push(input string req, input int kind, input logic [7:0] exp);
        item_t x;
        x.req = req; x.kind = kind; x.exp = exp;
        sb_q.push_back(x);
    endtask

    // start one bus cycle: drive after the edge
    task automatic op(input logic arm, input logic ent, input logic ex, input logic ws,
                      input logic wc, input logic wr, input logic rd,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        arm_lock = arm; id_enter = ent; id_exit = ex; wp_set = ws; wp_clr = wc;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    endtask

    // end the cycle: the edge registers it, then strobes drop
    task automatic fin;
        @(posedge clk); #1;
        arm_lock = 0; id_enter = 0; id_exit = 0; wp_set = 0; wp_clr = 0;
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        op(0,0,0,0,0,1,0,a,d);
    endtask

    task automatic rd(input logic [AW-1:0] a);
        op(0,0,0,0,0,0,1,a,'0);
    endtask

    task automatic arm;
        op(1,0,0,0,0,0,0,'0,'0); fin();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        push("R1 reset flags", K_STATUS, 8'h01);
        push("R10 status packing at reset", K_STATUS, 8'h01);

        // no identification mode yet
        rd(15'h0000);
        push("R6 no id data outside id mode", K_VALID, 8'h00);
        fin();

        // unarmed matching write is not taken
        wr(15'h0000, 8'h00);
        push("R13 write without arm not taken", K_TAKEN, 8'h00);
        fin();
        push("R13 no lock without arm", K_STATUS, 8'h01);

        // enter identification mode
        op(0,1,0,0,0,0,0,'0,'0); fin();
        rd(15'h0000); push("R7 manufacturer code", K_IDDATA, 8'h1F); fin();
        rd(15'h0001); push("R7 device code", K_IDDATA, 8'hDC); fin();
        rd(15'h0002); push("R8 lower unlocked", K_IDDATA, 8'hFE); fin();
        rd(15'h7FF2); push("R8 upper unlocked", K_IDDATA, 8'hFE); fin();
        rd(15'h0003); push("R9 other address", K_IDDATA, 8'h00); fin();
        rd(15'h1234); push("R9 other address far", K_IDDATA, 8'h00); fin();
        op(0,0,0,0,0,0,0,'0,'0);
        push("R6 valid needs read strobe", K_VALID, 8'h00);
        fin();

        // armed, non-matching pair: disarms only
        arm();
        wr(15'h5555, 8'hAA);
        push("R4 mismatched pair not taken", K_TAKEN, 8'h00);
        fin();
        push("R4 mismatched pair sets no lock", K_STATUS, 8'h01);
        wr(15'h0000, 8'h00);
        push("R4 disarmed after mismatch", K_TAKEN, 8'h00);
        fin();
        push("R4 no lock after disarm", K_STATUS, 8'h01);

        // armed, address 0 / data 0x00 locks lower region
        wr(15'h0100, 8'h12);
        push("R12 no block while unlocked", K_BLOCKED, 8'h00);
        fin();
        arm();
        wr(15'h0000, 8'h00);
        push("R2 lower lock write taken", K_TAKEN, 8'h01);
        push("R12 taken write not blocked", K_BLOCKED, 8'h00);
        fin();
        push("R2 lower lock set", K_STATUS, 8'h05);
        rd(15'h0002); push("R8 lower locked", K_IDDATA, 8'hFF); fin();
        wr(15'h0100, 8'h12); push("R12 lower region blocked", K_BLOCKED, 8'h01); fin();
        wr(15'h0FFF, 8'h12); push("R12 lower edge blocked", K_BLOCKED, 8'h01); fin();
        wr(15'h1000, 8'h12); push("R12 above lower region", K_BLOCKED, 8'h00); fin();
        wr(15'h7800, 8'h12); push("R12 upper not locked yet", K_BLOCKED, 8'h00); fin();

        // armed, top address / 0xFF locks upper region
        arm();
        wr(15'h7FFF, 8'hFF);
        push("R3 upper lock write taken", K_TAKEN, 8'h01);
        fin();
        push("R3 upper lock set", K_STATUS, 8'h07);
        rd(15'h7FF2); push("R8 upper locked", K_IDDATA, 8'hFF); fin();
        wr(15'h7000, 8'h12); push("R12 upper edge blocked", K_BLOCKED, 8'h01); fin();
        wr(15'h6FFF, 8'h12); push("R12 below upper region", K_BLOCKED, 8'h00); fin();

        // write-protect handling and lock stickiness
        op(0,0,0,0,1,0,0,'0,'0); fin();
        push("R11 protect cleared", K_STATUS, 8'h06);
        push("R5 locks survive protect clear", K_STATUS, 8'h06);
        op(0,0,0,1,1,0,0,'0,'0); fin();
        push("R11 simultaneous set and clear hold", K_STATUS, 8'h06);
        op(0,0,0,1,0,0,0,'0,'0); fin();
        push("R11 protect set", K_STATUS, 8'h07);
        op(0,0,0,1,1,0,0,'0,'0); fin();
        push("R11 simultaneous hold while set", K_STATUS, 8'h07);

        // leave identification mode; locks remain
        op(0,0,1,0,0,0,0,'0,'0); fin();
        rd(15'h0000);
        push("R6 id mode exited", K_VALID, 8'h00);
        fin();
        arm();
        wr(15'h1111, 8'h33); fin();
        op(0,0,0,0,1,0,0,'0,'0); fin();
        push("R5 locks still set", K_STATUS, 8'h06);

        @(negedge clk);
        @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule